// File: doc/BRIEF.md
# Host Bus Slave Handshake Unit

This block is the slave side of a peripheral's host bus port. The bus carries address and data on shared lines. An address strobe latches the register address and the transfer size. Read and write strobes then move the data. The unit turns these strobes into register read and write events. It drives the shared lines during reads. It also drives a single handshake line that tells the host when a cycle may complete.

The handshake line has two possible meanings: Ready/Wait or Acknowledge. Neither is chosen at reset. The meaning is fixed by the level of a mode input on the first write to the configuration register. Until that write occurs, the unit accepts nothing except that write, and the handshake line stays released. After it:
- In Acknowledge mode, the line goes low for register accesses, after a programmable access delay.
- In Ready/Wait mode, the line never moves for register accesses. It holds the host off only during interrupt acknowledge cycles.

The same mode also tells an outgoing master cycle how to read that line.

Top module: `hbus_hs_unit`

## Requirements
- R1: The first completed write to address CFG_ADDR latches the mode. `mode_sel` high selects Ready/Wait and low selects Acknowledge. Later writes, to any address and with any `mode_sel`, leave the mode unchanged.
- R2: Before that first configuration write, the following hold for every access: `hs_oe` is 0, `hs_n` is 1, `ad_oe` is 0, and `reg_rd` is 0. `reg_wr` pulses only for the configuration write itself.
- R3: In Ready/Wait mode, `hs_n` stays 1 throughout register reads and writes.
- R4: In Acknowledge mode, `hs_n` falls for a register access after `acc_dly`+1 rising clock edges. The count includes the first edge that sees the strobe active. `hs_n` returns to 1 one edge after the strobe ends.
- R5: An interrupt acknowledge cycle is a read strobe with `intack_n` low.
  - In Acknowledge mode, `hs_n` goes low once the delay has elapsed and `iack_ready` is 1.
  - In Ready/Wait mode, `hs_n` is low from the first edge until both of those are true, and then goes high.
- R6: A write is qualified by `cs_n` low only. `reg_wdata` is the last `ad_in` value seen while the strobe was active. `reg_wr` is a one-clock pulse, one edge after the strobe is seen inactive. A write strobe with `cs_n` high produces no pulse, even when `intack_n` is low.
- R7: A read strobe is qualified by `cs_n` low or `intack_n` low. One edge after the strobe is seen active, `ad_oe` is 1 and `ad_out` equals `rdata`. `ad_oe` clears one edge after the strobe ends. A register read (`cs_n` low, `intack_n` high) gives one `reg_rd` pulse.
- R8: Both fields are taken from `ad_in` on the edge that first sees `as_n` high after low:
  - `ad_in[0]` gives the size: 1 means byte and appears on `byte_sel`.
  - `ad_in[AW:1]` gives the register address on `reg_addr`.
- R9: `m_can_end` is 0 before configuration. In Ready/Wait mode it equals `m_hs_in`; in Acknowledge mode it equals the inverse of `m_hs_in`.
- R10: After configuration, `hs_oe` is 1 one edge after `cs_n` or `intack_n` is seen low, and 0 one edge after both are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| intack_n | input | 1 | Interrupt acknowledge, active low |
| as_n | input | 1 | Address strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| ad_in | input | DW | Address/data lines, inbound |
| mode_sel | input | 1 | Mode select, sampled on the first configuration write |
| acc_dly | input | DLY_W | Access delay in clocks |
| iack_ready | input | 1 | Interrupt logic is ready to finish the acknowledge |
| rdata | input | DW | Read data from the register file |
| m_hs_in | input | 1 | Handshake line level seen during a master cycle |
| ad_out | output | DW | Address/data lines, outbound |
| ad_oe | output | 1 | Output enable for `ad_out` |
| hs_n | output | 1 | Handshake line level |
| hs_oe | output | 1 | Output enable for `hs_n` |
| reg_addr | output | AW | Latched register address |
| byte_sel | output | 1 | Latched size: 1 = byte, 0 = word |
| reg_wdata | output | DW | Write data |
| reg_wr | output | 1 | Register write pulse |
| reg_rd | output | 1 | Register read pulse |
| cfg_done | output | 1 | Mode has been latched |
| mode_rdy | output | 1 | 1 = Ready/Wait mode, 0 = Acknowledge mode |
| m_can_end | output | 1 | A master cycle may complete |

## Verification
The assertions make three assumptions about the bus inputs:
- They are already synchronous to `clk`.
- A read or write strobe is inactive for at least one edge between cycles.
- The address phase, with `as_n` returning high, is finished before the data strobe falls.

The bench drives every input on the falling clock edge. It opens every cycle with a separate address phase. It releases all strobes for at least one full clock before the next cycle begins. Because of this, every edge-detected event in the design sees a clean low-to-high or high-to-low step.

// File: rtl/hbus_pkg.sv
// Package: shared types for the host bus handshake unit.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package hbus_pkg;
    // Meaning of the handshake line, fixed at configuration time.
    typedef enum logic {
        MODE_ACK = 1'b0,
        MODE_RDY = 1'b1
    } hs_mode_e;

    // Kind of slave cycle in progress.
    typedef enum logic [1:0] {
        CYC_NONE = 2'd0,
        CYC_REG  = 2'd1,
        CYC_IACK = 2'd2
    } cyc_kind_e;
endpackage

// File: rtl/hbus_strobe_decode.sv
// Strobe decoder: qualifies the bus strobes, latches the address and size
// at the end of the address phase, holds write data and flags cycle edges.
// Assumes all bus inputs are synchronous to clk.
module hbus_strobe_decode #(
    parameter int DW = 16,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          intack_n,
    input  logic          as_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic [DW-1:0] ad_in,
    output logic [AW-1:0] addr_q,
    output logic          byte_q,
    output logic [DW-1:0] wdata_q,
    output logic          wr_act,
    output logic          rd_reg,
    output logic          rd_iack,
    output logic          sel,
    output logic          wr_end,
    output logic          rd_reg_start
);
    logic as_q;
    logic wr_act_q;
    logic rd_reg_q;

    // Strobe qualification from current pin levels.
    always_comb begin
        wr_act       = !cs_n && !wr_n;
        rd_iack      = !intack_n && !rd_n;
        rd_reg       = !cs_n && intack_n && !rd_n;
        sel          = !cs_n || !intack_n;
        wr_end       = wr_act_q && !wr_act;
        rd_reg_start = rd_reg && !rd_reg_q;
    end

    // Edge history of address, write and read strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            as_q     <= 1'b1;
            wr_act_q <= 1'b0;
            rd_reg_q <= 1'b0;
        end else begin
            as_q     <= as_n;
            wr_act_q <= wr_act;
            rd_reg_q <= rd_reg;
        end
    end

    // Address and size capture at the rising edge of the address strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            byte_q <= 1'b0;
        end else if (!as_q && as_n) begin
            addr_q <= ad_in[AW:1];
            byte_q <= ad_in[0];
        end
    end

    // Write data follows the lines while the write strobe is active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wdata_q <= '0;
        end else if (wr_act) begin
            wdata_q <= ad_in;
        end
    end

    // A write cannot end on two edges in a row.
    a_r6_single_end: assert property (@(posedge clk) disable iff (!rst_n)
        wr_end |=> !wr_end)
        else $error("a_r6_single_end");
endmodule

// File: rtl/hbus_mode_latch.sv
// Mode latch: records the handshake meaning on the first configuration
// write and keeps it until reset. Assumes cfg_wr_evt is a one-clock pulse.
module hbus_mode_latch
    import hbus_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cfg_wr_evt,
    input  logic     mode_sel,
    output logic     cfg_done,
    output hs_mode_e mode
);
    // One-time capture of the mode-select level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_done <= 1'b0;
            mode     <= MODE_ACK;
        end else if (cfg_wr_evt && !cfg_done) begin
            cfg_done <= 1'b1;
            mode     <= mode_sel ? MODE_RDY : MODE_ACK;
        end
    end

    // R1: once latched, the mode and the done flag never change.
    a_r1_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done |=> cfg_done && $stable(mode))
        else $error("a_r1_mode_frozen");
endmodule

// File: rtl/hbus_hs_timer.sv
// Handshake timer: counts the access delay from the start of a slave cycle
// and produces the handshake level and its output enable for the latched
// mode. Assumes strobes are inactive for at least one edge between cycles.
module hbus_hs_timer
    import hbus_pkg::*;
#(
    parameter int DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_done,
    input  hs_mode_e         mode,
    input  cyc_kind_e        kind,
    input  logic             sel,
    input  logic             iack_ready,
    input  logic [DLY_W-1:0] acc_dly,
    output logic             hs_n,
    output logic             hs_oe
);
    logic [DLY_W-1:0] cnt;
    logic             active;
    logic             done;
    logic             hs_low_nx;

    // Cycle activity and delay expiry.
    always_comb begin
        active = cfg_done && (kind != CYC_NONE);
        done   = active && (cnt == acc_dly);
    end

    // Next handshake level for each mode and cycle kind.
    always_comb begin
        hs_low_nx = 1'b0;
        if (active) begin
            if (mode == MODE_ACK) begin
                hs_low_nx = (kind == CYC_IACK) ? (done && iack_ready) : done;
            end else if (kind == CYC_IACK) begin
                hs_low_nx = !(done && iack_ready);
            end
        end
    end

    // Delay counter, cleared whenever no cycle is active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!active) begin
            cnt <= '0;
        end else if (cnt != acc_dly) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Registered handshake level and enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_n  <= 1'b1;
            hs_oe <= 1'b0;
        end else begin
            hs_n  <= !hs_low_nx;
            hs_oe <= cfg_done && sel;
        end
    end

    // R2: nothing is driven before configuration.
    a_r2_quiet_unconfigured: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_done |=> hs_n && !hs_oe)
        else $error("a_r2_quiet_unconfigured");

    // R3: Ready/Wait mode never asserts for a register access.
    a_r3_rdy_reg_released: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RDY && kind == CYC_REG) |=> hs_n)
        else $error("a_r3_rdy_reg_released");

    // R10: the enable drops once the unit is deselected.
    a_r10_oe_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> !hs_oe)
        else $error("a_r10_oe_deselect");

    // R4: with no cycle in progress the line is released.
    a_r4_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == CYC_NONE) |=> hs_n)
        else $error("a_r4_idle_released");
endmodule

// File: rtl/hbus_hs_unit.sv
// Host bus slave handshake unit (top): joins the strobe decoder, mode latch
// and handshake timer, and produces register events and read data drive.
// Assumes synchronous bus inputs and AW < DW.
module hbus_hs_unit
    import hbus_pkg::*;
#(
    parameter int          DW       = 16,
    parameter int          AW       = 8,
    parameter int          DLY_W    = 4,
    parameter logic [AW-1:0] CFG_ADDR = 8'h1F
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             intack_n,
    input  logic             as_n,
    input  logic             rd_n,
    input  logic             wr_n,
    input  logic [DW-1:0]    ad_in,
    input  logic             mode_sel,
    input  logic [DLY_W-1:0] acc_dly,
    input  logic             iack_ready,
    input  logic [DW-1:0]    rdata,
    input  logic             m_hs_in,
    output logic [DW-1:0]    ad_out,
    output logic             ad_oe,
    output logic             hs_n,
    output logic             hs_oe,
    output logic [AW-1:0]    reg_addr,
    output logic             byte_sel,
    output logic [DW-1:0]    reg_wdata,
    output logic             reg_wr,
    output logic             reg_rd,
    output logic             cfg_done,
    output logic             mode_rdy,
    output logic             m_can_end
);
    logic      wr_act, rd_reg, rd_iack, sel, wr_end, rd_reg_start;
    logic      cfg_hit, cfg_wr_evt, rd_any;
    hs_mode_e  mode;
    cyc_kind_e kind;

    hbus_strobe_decode #(.DW(DW), .AW(AW)) u_dec (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .intack_n(intack_n),
        .as_n(as_n), .rd_n(rd_n), .wr_n(wr_n), .ad_in(ad_in),
        .addr_q(reg_addr), .byte_q(byte_sel), .wdata_q(reg_wdata),
        .wr_act(wr_act), .rd_reg(rd_reg), .rd_iack(rd_iack), .sel(sel),
        .wr_end(wr_end), .rd_reg_start(rd_reg_start)
    );

    // Configuration write detection and cycle classification.
    always_comb begin
        cfg_hit    = (reg_addr == CFG_ADDR);
        cfg_wr_evt = wr_end && cfg_hit;
        rd_any     = rd_reg || rd_iack;
        if (rd_iack)              kind = CYC_IACK;
        else if (wr_act || rd_reg) kind = CYC_REG;
        else                      kind = CYC_NONE;
    end

    hbus_mode_latch u_mode (
        .clk(clk), .rst_n(rst_n), .cfg_wr_evt(cfg_wr_evt),
        .mode_sel(mode_sel), .cfg_done(cfg_done), .mode(mode)
    );

    hbus_hs_timer #(.DLY_W(DLY_W)) u_hs (
        .clk(clk), .rst_n(rst_n), .cfg_done(cfg_done), .mode(mode),
        .kind(kind), .sel(sel), .iack_ready(iack_ready), .acc_dly(acc_dly),
        .hs_n(hs_n), .hs_oe(hs_oe)
    );

    // Register event pulses, gated until configured except the config write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_wr <= 1'b0;
            reg_rd <= 1'b0;
        end else begin
            reg_wr <= wr_end && (cfg_done || cfg_hit);
            reg_rd <= rd_reg_start && cfg_done;
        end
    end

    // Read data drive while a qualified read strobe is active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ad_oe  <= 1'b0;
            ad_out <= '0;
        end else begin
            ad_oe <= rd_any && cfg_done;
            if (rd_any && cfg_done) ad_out <= rdata;
        end
    end

    // Mode flag and master-cycle completion rule.
    always_comb begin
        mode_rdy  = (mode == MODE_RDY);
        m_can_end = cfg_done && (mode_rdy ? m_hs_in : !m_hs_in);
    end

    // R6: a write pulse lasts one clock.
    a_r6_wr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr)
        else $error("a_r6_wr_pulse");

    // R7: data is driven only after a read strobe was seen low.
    a_r7_oe_after_rd: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe |-> !$past(rd_n))
        else $error("a_r7_oe_after_rd");

    // R2: no read pulse before configuration.
    a_r2_no_rd_unconf: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_done |=> !reg_rd)
        else $error("a_r2_no_rd_unconf");
endmodule

// File: tb/hbus_hs_unit_tb.sv
module hbus_hs_unit_tb;
    localparam int DW = 16;
    localparam int AW = 8;
    localparam int DLY_W = 4;
    localparam logic [AW-1:0] CFG = 8'h1F;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1, intack_n = 1, as_n = 1, rd_n = 1, wr_n = 1;
    logic [DW-1:0] ad_in = '0;
    logic mode_sel = 0;
    logic [DLY_W-1:0] acc_dly = '0;
    logic iack_ready = 0;
    logic [DW-1:0] rdata = '0;
    logic m_hs_in = 1;
    logic [DW-1:0] ad_out;
    logic ad_oe, hs_n, hs_oe, byte_sel, reg_wr, reg_rd, cfg_done, mode_rdy, m_can_end;
    logic [AW-1:0] reg_addr;
    logic [DW-1:0] reg_wdata;

    always #4 clk = ~clk;

    hbus_hs_unit #(.DW(DW), .AW(AW), .DLY_W(DLY_W), .CFG_ADDR(CFG)) u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .intack_n(intack_n), .as_n(as_n),
        .rd_n(rd_n), .wr_n(wr_n), .ad_in(ad_in), .mode_sel(mode_sel),
        .acc_dly(acc_dly), .iack_ready(iack_ready), .rdata(rdata), .m_hs_in(m_hs_in),
        .ad_out(ad_out), .ad_oe(ad_oe), .hs_n(hs_n), .hs_oe(hs_oe),
        .reg_addr(reg_addr), .byte_sel(byte_sel), .reg_wdata(reg_wdata),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .cfg_done(cfg_done), .mode_rdy(mode_rdy),
        .m_can_end(m_can_end)
    );

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic          bsel;
    } wr_item_t;

    wr_item_t exp_q[$];
    int n_chk = 0;
    int n_fail = 0;
    int wr_seen = 0;
    int rd_seen = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on each write pulse (R6, R8).
    always @(negedge clk) begin
        if (rst_n && reg_rd) rd_seen++;
        if (rst_n && reg_wr) begin
            wr_seen++;
            if (exp_q.size() == 0) begin
                chk(0, "R2/R6 unexpected reg_wr", {24'd0, reg_addr}, 32'd0);
            end else begin
                wr_item_t e;
                e = exp_q.pop_front();
                chk(reg_addr == e.addr, "R8 reg_addr", {24'd0, reg_addr}, {24'd0, e.addr});
                chk(byte_sel == e.bsel, "R8 byte_sel", {31'd0, byte_sel}, {31'd0, e.bsel});
                chk(reg_wdata == e.data, "R6 reg_wdata", {16'd0, reg_wdata}, {16'd0, e.data});
            end
        end
    end

    task automatic addr_phase(input logic [AW-1:0] a, input logic b);
        @(negedge clk); as_n = 0; ad_in = {{(DW-AW-1){1'b0}}, a, b};
        @(negedge clk); as_n = 1;
        @(negedge clk); ad_in = '0;
    endtask

    // Driver: a write cycle; hs_exp=1 means the line must fall after D+1 edges.
    task automatic wr_cyc(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic b,
                          input bit push, input bit hs_exp, input string req);
        int dly;
        dly = int'(acc_dly);
        if (push) exp_q.push_back('{addr: a, data: d, bsel: b});
        addr_phase(a, b);
        cs_n = 0; wr_n = 0; ad_in = d ^ 16'hFFFF;
        @(negedge clk); ad_in = d;
        if (dly > 0) begin
            repeat (dly - 1) @(negedge clk);
            chk(hs_n == 1'b1, {req, " hs before delay"}, {31'd0, hs_n}, 32'd1);
        end
        @(negedge clk);
        chk(hs_n == !hs_exp, {req, " hs after delay"}, {31'd0, hs_n}, {31'd0, !hs_exp});
        wr_n = 1; cs_n = 1;
        @(negedge clk);
        chk(hs_n == 1'b1, {req, " hs release"}, {31'd0, hs_n}, 32'd1);
        @(negedge clk);
    endtask

    initial begin
        int w0;
        repeat (3) @(negedge clk);
        // Reset state (R2, R9)
        chk(hs_n === 1'b1 && hs_oe === 1'b0, "R2 reset hs", {30'd0, hs_n, hs_oe}, 32'd2);
        chk(ad_oe === 1'b0 && reg_wr === 1'b0, "R2 reset ad_oe/reg_wr", {30'd0, ad_oe, reg_wr}, 32'd0);
        chk(m_can_end === 1'b0, "R9 reset m_can_end", {31'd0, m_can_end}, 32'd0);
        rst_n = 1;
        @(negedge clk);

        // R2: unconfigured write and read are ignored
        w0 = wr_seen;
        acc_dly = 4'd1;
        wr_cyc(8'h05, 16'h1234, 1'b0, 0, 0, "R2 unconfigured write");
        @(negedge clk);
        chk(wr_seen == w0, "R2 no reg_wr", wr_seen, w0);
        addr_phase(8'h05, 1'b0);
        rdata = 16'hBEEF; cs_n = 0; rd_n = 0;
        @(negedge clk); @(negedge clk);
        chk(ad_oe == 1'b0 && hs_oe == 1'b0, "R2 unconfigured read", {30'd0, ad_oe, hs_oe}, 32'd0);
        rd_n = 1; cs_n = 1;
        @(negedge clk);
        chk(rd_seen == 0, "R2 no reg_rd", rd_seen, 0);

        // R1: configuration write with mode_sel low -> Acknowledge
        mode_sel = 0;
        wr_cyc(CFG, 16'h00A5, 1'b1, 1, 0, "R2 cfg write hs");
        chk(cfg_done == 1'b1 && mode_rdy == 1'b0, "R1 ack mode latched", {30'd0, cfg_done, mode_rdy}, 32'd2);
        mode_sel = 1;
        acc_dly = 4'd2;
        wr_cyc(CFG, 16'h5A00, 1'b0, 1, 1, "R1/R4 second cfg write");
        chk(mode_rdy == 1'b0, "R1 mode unchanged", {31'd0, mode_rdy}, 32'd0);

        // R4/R6/R8: Acknowledge-mode register write, word and byte
        acc_dly = 4'd3;
        wr_cyc(8'h42, 16'hC0DE, 1'b0, 1, 1, "R4 ack write d3");
        acc_dly = 4'd0;
        wr_cyc(8'h7E, 16'h0011, 1'b1, 1, 1, "R4 ack write d0");

        // R7/R10: register read in Acknowledge mode
        addr_phase(8'h10, 1'b0);
        rdata = 16'hA1B2; cs_n = 0; rd_n = 0;
        @(negedge clk);
        chk(ad_oe == 1'b1 && ad_out == 16'hA1B2, "R7 read data", {15'd0, ad_oe, ad_out}, 32'h1A1B2);
        chk(hs_n == 1'b0 && hs_oe == 1'b1, "R4/R10 read hs", {30'd0, hs_n, hs_oe}, 32'd1);
        rd_n = 1; cs_n = 1;
        @(negedge clk);
        chk(ad_oe == 1'b0 && hs_oe == 1'b0, "R7/R10 read end", {30'd0, ad_oe, hs_oe}, 32'd0);
        chk(rd_seen == 1, "R7 one reg_rd", rd_seen, 1);

        // R6: write strobe with intack low and cs high is ignored
        w0 = wr_seen;
        intack_n = 0; wr_n = 0; ad_in = 16'h9999;
        @(negedge clk); @(negedge clk);
        chk(hs_n == 1'b1 && hs_oe == 1'b1, "R6/R10 intack write strobe", {30'd0, hs_n, hs_oe}, 32'd3);
        wr_n = 1; intack_n = 1;
        @(negedge clk); @(negedge clk);
        chk(wr_seen == w0, "R6 unqualified write", wr_seen, w0);

        // R5: interrupt acknowledge in Acknowledge mode
        acc_dly = 4'd1; iack_ready = 0; rdata = 16'h0044;
        intack_n = 0; rd_n = 0;
        repeat (4) @(negedge clk);
        chk(hs_n == 1'b1, "R5 ack iack waits", {31'd0, hs_n}, 32'd1);
        chk(ad_oe == 1'b1 && ad_out == 16'h0044, "R7 iack read data", {15'd0, ad_oe, ad_out}, 32'h10044);
        iack_ready = 1;
        @(negedge clk);
        chk(hs_n == 1'b0, "R5 ack iack done", {31'd0, hs_n}, 32'd0);
        rd_n = 1; intack_n = 1; iack_ready = 0;
        @(negedge clk);

        // R9: Acknowledge mode completion rule
        m_hs_in = 0; #1;
        chk(m_can_end == 1'b1, "R9 ack low ends", {31'd0, m_can_end}, 32'd1);
        m_hs_in = 1; #1;
        chk(m_can_end == 1'b0, "R9 ack high waits", {31'd0, m_can_end}, 32'd0);

        // Reset and configure Ready/Wait mode
        @(negedge clk); rst_n = 0;
        @(negedge clk); @(negedge clk); rst_n = 1;
        chk(cfg_done == 1'b0, "R1 reset clears config", {31'd0, cfg_done}, 32'd0);
        mode_sel = 1; acc_dly = 4'd2;
        wr_cyc(CFG, 16'h0F0F, 1'b0, 1, 0, "R2 cfg write rdy");
        chk(cfg_done == 1'b1 && mode_rdy == 1'b1, "R1 rdy mode latched", {30'd0, cfg_done, mode_rdy}, 32'd3);

        // R3: Ready/Wait register write and read leave hs released
        wr_cyc(8'h33, 16'h7777, 1'b1, 1, 0, "R3 rdy write");
        addr_phase(8'h33, 1'b0);
        rdata = 16'h2468; cs_n = 0; rd_n = 0;
        repeat (4) @(negedge clk);
        chk(hs_n == 1'b1 && hs_oe == 1'b1, "R3 rdy read hs", {30'd0, hs_n, hs_oe}, 32'd3);
        chk(ad_out == 16'h2468, "R7 rdy read data", {16'd0, ad_out}, 32'h2468);
        rd_n = 1; cs_n = 1;
        @(negedge clk);

        // R5: Ready/Wait interrupt acknowledge holds the line low until ready
        acc_dly = 4'd0; iack_ready = 0;
        intack_n = 0; rd_n = 0;
        @(negedge clk);
        chk(hs_n == 1'b0, "R5 rdy iack wait", {31'd0, hs_n}, 32'd0);
        repeat (3) @(negedge clk);
        chk(hs_n == 1'b0, "R5 rdy iack still wait", {31'd0, hs_n}, 32'd0);
        iack_ready = 1;
        @(negedge clk);
        chk(hs_n == 1'b1, "R5 rdy iack ready", {31'd0, hs_n}, 32'd1);
        rd_n = 1; intack_n = 1; iack_ready = 0;
        @(negedge clk);

        // R9: Ready/Wait completion rule
        m_hs_in = 0; #1;
        chk(m_can_end == 1'b0, "R9 rdy low waits", {31'd0, m_can_end}, 32'd0);
        m_hs_in = 1; #1;
        chk(m_can_end == 1'b1, "R9 rdy high ends", {31'd0, m_can_end}, 32'd1);

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R6 scoreboard drained", exp_q.size(), 0);
        finished = 1;
    end

    // Watchdog and summary.
    initial begin
        int cyc;
        cyc = 0;
        while (!finished && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule